// File: doc/BRIEF.md
# Board Control Register Block

This block is a small set of memory-mapped words on a 32-bit bus that is addressed in bytes and accessed in aligned words. Software uses it to learn the system clock rate, to read a bank of eight configuration switches, and to request a reset of the whole system.

The clock rate is a constant fixed when the design is built. The switch inputs are asynchronous to the bus clock, so they pass through a two-stage synchroniser before a read can return them. A reset is requested by writing one specific 32-bit key to a dedicated word. The block then holds its reset output high for a parameterised number of cycles. Any other write to that word does nothing.

Every bus access, whether a read or a write and whether mapped or not, is acknowledged exactly one cycle after it is presented.

Top module: `board_ctl_regs`

## Requirements
- R1: A read of byte offset 0x04 returns the build-time parameter CLK_HZ (default 50,000,000) as a 32-bit word.
- R2: A read of byte offset 0x0C returns the synchronised switch state in bits [7:0], with bit i equal to switch i, and zero in bits [31:8].
- R3: Each switch input passes through two flops before the read mux. A read presented in the same cycle as a switch change returns the old value. A read presented three or more cycles later returns the new value.
- R4: A write of exactly 0x0000DEAD (all 32 bits compared) to byte offset 0x10 raises sys_rst_out in the cycle after the write. The output then stays high for RST_CYCLES cycles (default 16) and falls back low.
- R5: A write of any other value to offset 0x10 leaves sys_rst_out low.
- R6: Offset 0x10 is write-only. A read there returns zero and never raises sys_rst_out, even when the write-data lines carry 0x0000DEAD.
- R7: Writes to offsets 0x04 and 0x0C are ignored. Later reads of those offsets return the same values as before.
- R8: A read of an unmapped or non-word-aligned offset returns zero. A key write to a non-aligned offset such as 0x11 does not raise sys_rst_out.
- R9: bus_ready is high exactly in the cycle after each cycle in which bus_req is high. bus_rdata is zero whenever bus_ready is low, and zero after a write.
- R10: While rst is high at a clock edge, bus_ready, bus_rdata and sys_rst_out are cleared, and a reset pulse in progress is cut short.
- R11: A key write during an active pulse restarts the count. The output stays high for RST_CYCLES cycles after the most recent key write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid with bus_ready |
| bus_ready | output | 1 | One-cycle acknowledge of each access |
| dip_sw | input | 8 | Asynchronous switch inputs |
| sys_rst_out | output | 1 | System reset pulse, active high |

## Verification
The assertions take two things for granted about the inputs. First, bus_req is a single-cycle strobe. Second, bus_we, bus_addr and bus_wdata are settled at the clock edge on which bus_req is sampled. The stimulus drives every input on the falling clock edge and keeps each strobe to one cycle, so it stays within these assumptions. The switch inputs are treated as asynchronous, and the checks never sample them directly. The bench changes the switches only on falling edges and judges their effect through timed reads after the synchroniser latency.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned OFF_CLKRATE = 32'h04;
  localparam int unsigned OFF_SWITCH  = 32'h0C;
  localparam int unsigned OFF_RSTKEY  = 32'h10;
  localparam logic [31:0] RST_KEY     = 32'h0000_DEAD;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_CLK    = 2'd1,
    SEL_SWITCH = 2'd2,
    SEL_RSTKEY = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/bcr_sync.sv
module bcr_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/bcr_decode.sv
module bcr_decode
  import bcr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SW_W   = 8,
  parameter logic [31:0] CLK_HZ = 32'd50_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [SW_W-1:0]   sw_sync,
  output logic [WORD_W-1:0] rdata_q,
  output logic              ready_q,
  output logic              key_hit
);
  localparam logic [ADDR_W-1:0] A_CLK = ADDR_W'(OFF_CLKRATE);
  localparam logic [ADDR_W-1:0] A_SW  = ADDR_W'(OFF_SWITCH);
  localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(OFF_RSTKEY);

  reg_sel_e          sel;
  logic [WORD_W-1:0] rd_mux;

  always_comb begin
    unique case (addr)
      A_CLK:   sel = SEL_CLK;
      A_SW:    sel = SEL_SWITCH;
      A_KEY:   sel = SEL_RSTKEY;
      default: sel = SEL_NONE;
    endcase
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CLK:    rd_mux = CLK_HZ;
      SEL_SWITCH: rd_mux = WORD_W'(sw_sync);
      default:    rd_mux = '0;
    endcase
  end

  assign key_hit = req && we && (sel == SEL_RSTKEY) && (wdata == RST_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      ready_q <= req;
      rdata_q <= (req && !we) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/bcr_rst_pulse.sv
module bcr_rst_pulse #(
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic pulse_q
);
  localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(RST_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (trig)            cnt <= LOAD;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
      pulse_q <= trig || (cnt > CNT_W'(1));
    end
  end
endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
  import bcr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SW_W        = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_CYCLES  = 16,
  parameter logic [31:0] CLK_HZ      = 32'd50_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready,
  input  logic [SW_W-1:0]   dip_sw,
  output logic              sys_rst_out
);
  logic [SW_W-1:0] sw_sync;
  logic            key_hit;

  bcr_sync #(.WIDTH(SW_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(dip_sw), .q_sync(sw_sync)
  );

  bcr_decode #(.ADDR_W(ADDR_W), .SW_W(SW_W), .CLK_HZ(CLK_HZ)) u_dec (
    .clk(clk), .rst(rst), .req(bus_req), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .sw_sync(sw_sync), .rdata_q(bus_rdata),
    .ready_q(bus_ready), .key_hit(key_hit)
  );

  bcr_rst_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
    .clk(clk), .rst(rst), .trig(key_hit), .pulse_q(sys_rst_out)
  );
endmodule

// File: rtl/bcr_checker.sv
module bcr_checker
  import bcr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned RST_CYCLES = 16,
  parameter logic [31:0] CLK_HZ     = 32'd50_000_000
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              bus_ready,
  input logic              sys_rst_out
);
  localparam int unsigned SW = $clog2(RST_CYCLES + 1) + 1;

  logic          key_wr;
  logic          armed;
  logic [SW-1:0] since;

  assign key_wr = bus_req && bus_we && (bus_addr == ADDR_W'(OFF_RSTKEY))
                  && (bus_wdata == RST_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      since <= '0;
    end else if (key_wr) begin
      armed <= 1'b1;
      since <= '0;
    end else if (armed && since < SW'(RST_CYCLES)) begin
      since <= since + 1'b1;
    end
  end

  p_ready_follows_req_r9: assert property (@(posedge clk) disable iff (rst)
    bus_req |=> bus_ready);
  p_no_spurious_ready_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_req |=> !bus_ready);
  p_rdata_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_ready |-> bus_rdata == 32'd0);
  p_clk_rate_read_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we && bus_addr == ADDR_W'(OFF_CLKRATE)) |=> bus_rdata == CLK_HZ);
  p_key_read_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we && bus_addr == ADDR_W'(OFF_RSTKEY)) |=> bus_rdata == 32'd0);
  p_key_starts_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    key_wr |=> sys_rst_out);
  p_pulse_window_r11: assert property (@(posedge clk) disable iff (rst)
    sys_rst_out == (armed && since < SW'(RST_CYCLES)));
endmodule

bind board_ctl_regs bcr_checker #(
  .ADDR_W(ADDR_W), .RST_CYCLES(RST_CYCLES), .CLK_HZ(CLK_HZ)
) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_ready(bus_ready), .sys_rst_out(sys_rst_out)
);

// File: tb/tb_board_ctl_regs.sv
`timescale 1ns/1ps
module tb_board_ctl_regs;
  localparam logic [31:0] CLK_HZ = 32'd50_000_000;
  localparam int RST_CYCLES = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic [7:0]  dip_sw = 8'h00;
  logic        sys_rst_out;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  board_ctl_regs #(.CLK_HZ(CLK_HZ), .RST_CYCLES(RST_CYCLES)) dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .dip_sw(dip_sw), .sys_rst_out(sys_rst_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One access: drive on falling edge, sample on the next falling edge.
  task automatic access(input logic we, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic rdy);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    rd = bus_rdata; rdy = bus_ready;
    bus_req = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  // Count consecutive cycles sys_rst_out stays high, starting now.
  task automatic count_high(output int n);
    n = 0;
    while (sys_rst_out && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_state;
    check("R10 ready in reset", {31'd0, bus_ready}, 32'd0);
    check("R10 rdata in reset", bus_rdata, 32'd0);
    check("R10 rst_out in reset", {31'd0, sys_rst_out}, 32'd0);
  endtask

  task automatic t_clk_rate;
    logic [31:0] rd; logic rdy;
    access(1'b0, 8'h04, 32'h0, rd, rdy);
    check("R1 clock rate", rd, CLK_HZ);
    check("R9 ready on read", {31'd0, rdy}, 32'd1);
    @(negedge clk);
    check("R9 ready drops", {31'd0, bus_ready}, 32'd0);
    check("R9 rdata idle zero", bus_rdata, 32'd0);
  endtask

  task automatic t_switches;
    logic [31:0] rd; logic rdy;
    @(negedge clk); dip_sw = 8'hA5;
    repeat (4) @(negedge clk);
    access(1'b0, 8'h0C, 32'h0, rd, rdy);
    check("R2 switches A5", rd, 32'h0000_00A5);
    @(negedge clk); dip_sw = 8'h3C;
    repeat (4) @(negedge clk);
    access(1'b0, 8'h0C, 32'h0, rd, rdy);
    check("R2 switches 3C", rd, 32'h0000_003C);
  endtask

  task automatic t_sync_latency;
    logic [31:0] rd; logic rdy;
    @(negedge clk);
    dip_sw = 8'h5A; bus_req = 1'b1; bus_we = 1'b0; bus_addr = 8'h0C;
    @(negedge clk);
    rd = bus_rdata; bus_req = 1'b0;
    check("R3 same-cycle read old", rd, 32'h0000_003C);
    @(negedge clk);
    access(1'b0, 8'h0C, 32'h0, rd, rdy);
    check("R3 later read new", rd, 32'h0000_005A);
  endtask

  task automatic t_key_pulse;
    logic [31:0] rd; logic rdy; int n;
    access(1'b1, 8'h10, 32'h0000_DEAD, rd, rdy);
    check("R9 write rdata zero", rd, 32'd0);
    count_high(n);
    check("R4 pulse length", n, RST_CYCLES);
    check("R4 pulse released", {31'd0, sys_rst_out}, 32'd0);
  endtask

  task automatic t_bad_key;
    logic [31:0] rd; logic rdy; int bad_ok;
    bad_ok = 1;
    access(1'b1, 8'h10, 32'h0000_DEAE, rd, rdy);
    if (sys_rst_out) bad_ok = 0;
    access(1'b1, 8'h10, 32'h0001_DEAD, rd, rdy);
    if (sys_rst_out) bad_ok = 0;
    access(1'b1, 8'h10, 32'h0000_0000, rd, rdy);
    if (sys_rst_out) bad_ok = 0;
    repeat (2) @(negedge clk);
    if (sys_rst_out) bad_ok = 0;
    check("R5 wrong key no reset", bad_ok, 1);
  endtask

  task automatic t_key_read;
    logic [31:0] rd; logic rdy;
    access(1'b0, 8'h10, 32'h0000_DEAD, rd, rdy);
    check("R6 key read zero", rd, 32'd0);
    check("R6 key read no reset", {31'd0, sys_rst_out}, 32'd0);
  endtask

  task automatic t_ro_writes;
    logic [31:0] rd; logic rdy;
    access(1'b1, 8'h04, 32'hFFFF_FFFF, rd, rdy);
    access(1'b1, 8'h0C, 32'h0000_00FF, rd, rdy);
    access(1'b0, 8'h04, 32'h0, rd, rdy);
    check("R7 clock rate unchanged", rd, CLK_HZ);
    access(1'b0, 8'h0C, 32'h0, rd, rdy);
    check("R7 switches unchanged", rd, 32'h0000_005A);
  endtask

  task automatic t_unmapped;
    logic [31:0] rd; logic rdy;
    access(1'b0, 8'h00, 32'h0, rd, rdy);
    check("R8 unmapped 00 zero", rd, 32'd0);
    access(1'b0, 8'h05, 32'h0, rd, rdy);
    check("R8 unaligned 05 zero", rd, 32'd0);
    access(1'b0, 8'hFC, 32'h0, rd, rdy);
    check("R8 unmapped FC zero", rd, 32'd0);
    check("R9 ready on unmapped", {31'd0, rdy}, 32'd1);
    access(1'b1, 8'h11, 32'h0000_DEAD, rd, rdy);
    check("R8 unaligned key no reset", {31'd0, sys_rst_out}, 32'd0);
  endtask

  task automatic t_retrigger;
    logic [31:0] rd; logic rdy; int n;
    access(1'b1, 8'h10, 32'h0000_DEAD, rd, rdy);
    repeat (5) @(negedge clk);
    check("R11 still high mid-pulse", {31'd0, sys_rst_out}, 32'd1);
    access(1'b1, 8'h10, 32'h0000_DEAD, rd, rdy);
    count_high(n);
    check("R11 restarted length", n, RST_CYCLES);
  endtask

  task automatic t_reset_abort;
    logic [31:0] rd; logic rdy;
    access(1'b1, 8'h10, 32'h0000_DEAD, rd, rdy);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 pulse cut by reset", {31'd0, sys_rst_out}, 32'd0);
    repeat (RST_CYCLES + 2) @(negedge clk);
    check("R10 stays low after reset", {31'd0, sys_rst_out}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    @(negedge clk);
    t_clk_rate();
    t_switches();
    t_sync_latency();
    t_key_pulse();
    t_bad_key();
    t_key_read();
    t_ro_writes();
    t_unmapped();
    t_retrigger();
    t_reset_abort();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule